// File: doc/BRIEF.md
# Address-Range Cache Maintenance Sequencer

This block sweeps every entry of a two-way, 128-set tag store (16-byte lines, 21-bit tags) and applies one of three software-selected maintenance actions to the lines whose address lies inside an inclusive window. A clean pushes modified lines out to memory and marks them unmodified. An invalidate discards matching lines. A combined clean-and-invalidate does both. The tag store sits inside the block. Normal cache traffic reaches it through a lookup port that always wins arbitration. Write-backs leave through a request/acknowledge line-write port that stands in for the bus master.

Software programs a window as address bits 31:4 (`range_lo`, `range_hi`) and writes a 3-bit action code. It then pulses a start request. An accepted request shows as a pending-start bit for one cycle and then becomes a busy flag. When the sweep has visited all 256 entries, busy drops and a sticky finish flag rises. The finish flag stays high until it is cleared explicitly.

Top module: `rm_range_maint`

## Requirements
- R1: A start request is taken only when `cache_en` is 1, `full_inv_busy` is 0, no sweep is busy, no start is pending and the action code is 3'b001 (clean), 3'b010 (invalidate) or 3'b011 (clean and invalidate). Code 3'b000 and codes 3'b100 to 3'b111 start nothing.
- R2: An accepted request sets `start_pend` at the next edge. On the edge after that, `start_pend` returns to 0 and `cmd_busy` becomes 1.
- R3: `code_we` updates `cmd_code` only in cycles where `cmd_busy` and `start_pend` are both 0. Otherwise the write is dropped.
- R4: A valid line matches when `range_lo <= {tag, set} <= range_hi`, where the 28-bit value `{tag[20:0], set[6:0]}` is line address bits 31:4. Both bounds are included.
- R5: Invalidate sets valid, dirty, privilege and tag to 0 for every matching line. It issues no write-back.
- R6: Clean issues one write-back for each matching line whose dirty bit is set. It then clears only that dirty bit, so the line stays valid with its tag and privilege bit. Matching lines that are not dirty are left untouched.
- R7: Clean-and-invalidate writes back every matching dirty line and clears all fields of every matching line, dirty or not.
- R8: In any cycle where `lk_req` is 1, the sweep neither reads nor writes the tag store and does not advance. A sweep with `lk_req` held high makes no progress.
- R9: Entries are visited in ascending set order, with way 0 before way 1 within a set. While a write-back is outstanding the sweep waits: `wb_req`, `wb_addr` and `wb_priv` hold steady until `wb_ack`.
- R10: A write-back carries `wb_addr = {tag, set, 4'b0000}` and `wb_priv` equal to the line's privilege bit, and it has `wb_incr` = 1 (one incrementing full-line burst).
- R11: After the last entry has been handled, `cmd_busy` falls and `cmd_end` is 1 in the same cycle. `cmd_end` stays 1 until `end_clr` is pulsed, and the cycle after that pulse it reads 0.
- R12: After reset all entries are invalid and `cmd_code`, `start_pend`, `cmd_busy`, `cmd_end` and `wb_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enabled; required to accept a start |
| full_inv_busy | input | 1 | Whole-cache invalidate in progress; blocks a start |
| code_we | input | 1 | Write strobe for the action code |
| code_wdata | input | 3 | Action code to write |
| start_req | input | 1 | Software start request |
| end_clr | input | 1 | Clears the finish flag |
| range_lo | input | 28 | Window low bound, address bits 31:4 |
| range_hi | input | 28 | Window high bound, address bits 31:4 |
| lk_req | input | 1 | Normal lookup owns the tag port this cycle |
| lk_we | input | 1 | Lookup writes the addressed entry |
| lk_way | input | 1 | Lookup way |
| lk_set | input | 7 | Lookup set |
| lk_wvalid | input | 1 | Valid bit to write |
| lk_wdirty | input | 1 | Dirty bit to write |
| lk_wpriv | input | 1 | Privilege bit to write |
| lk_wtag | input | 21 | Tag to write |
| lk_rvalid | output | 1 | Valid bit of the addressed entry |
| lk_rdirty | output | 1 | Dirty bit of the addressed entry |
| lk_rpriv | output | 1 | Privilege bit of the addressed entry |
| lk_rtag | output | 21 | Tag of the addressed entry |
| wb_req | output | 1 | Line write-back requested |
| wb_addr | output | 32 | Line base address of the write-back |
| wb_priv | output | 1 | Privilege attribute of the write-back |
| wb_incr | output | 1 | Incrementing full-line burst marker |
| wb_ack | input | 1 | Write-back accepted |
| cmd_code | output | 3 | Current action code |
| start_pend | output | 1 | Accepted start waiting to launch |
| cmd_busy | output | 1 | Sweep in progress |
| cmd_end | output | 1 | Sticky sweep-finished flag |

## Verification
The lookup read path is combinational, so entry contents are checked in the same cycle the address is applied. A pulse on `start_req` shows up on `start_pend` one edge later and on `cmd_busy` two edges later, and the bench samples at the falling edge after each of those edges. Write-backs are matched in order against a list the bench builds from its own mirror of the store. Each request is compared on the first falling edge where it is seen, and the acknowledge is returned after a random delay. `cmd_end` and the full store contents are checked only after the falling edge at which `cmd_busy` is first seen low.

// File: rtl/rm_pkg.sv
package rm_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int WAYS       = 2;
    localparam int SETS       = 128;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = $clog2(WAYS);
    localparam int TAG_W      = ADDR_W - SET_W - OFS_W;
    localparam int IDX_W      = SET_W + WAY_W;
    localparam int ENTRIES    = WAYS * SETS;
    localparam int RNG_W      = ADDR_W - OFS_W;

    typedef enum logic [2:0] {
        MC_NOP   = 3'b000,
        MC_CLEAN = 3'b001,
        MC_INV   = 3'b010,
        MC_CLINV = 3'b011
    } mcmd_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             priv;
        logic [TAG_W-1:0] tag;
    } tag_ent_t;

    function automatic logic cmd_legal(input logic [2:0] c);
        return (c == MC_CLEAN) || (c == MC_INV) || (c == MC_CLINV);
    endfunction

    function automatic logic cmd_cleans(input logic [2:0] c);
        return (c == MC_CLEAN) || (c == MC_CLINV);
    endfunction

    function automatic logic cmd_invals(input logic [2:0] c);
        return (c == MC_INV) || (c == MC_CLINV);
    endfunction

    function automatic logic line_in_window(input tag_ent_t e, input logic [SET_W-1:0] s,
                                            input logic [RNG_W-1:0] lo, input logic [RNG_W-1:0] hi);
        logic [RNG_W-1:0] la;
        la = {e.tag, s};
        return e.valid && (la >= lo) && (la <= hi);
    endfunction
endpackage

// File: rtl/rm_tag_store.sv
module rm_tag_store
    import rm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] addr,
    input  logic             we,
    input  tag_ent_t         wdata,
    output tag_ent_t         rdata
);
    tag_ent_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rm_ctrl.sv
module rm_ctrl
    import rm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cache_en,
    input  logic       full_inv_busy,
    input  logic       code_we,
    input  logic [2:0] code_wdata,
    input  logic       start_req,
    input  logic       end_clr,
    input  logic       walk_busy,
    input  logic       walk_done,
    output logic [2:0] cmd_code,
    output logic       start_pend,
    output logic       cmd_end
);
    logic accept;

    assign accept = start_req && cache_en && !full_inv_busy && !walk_busy
                    && !start_pend && cmd_legal(cmd_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_code   <= MC_NOP;
            start_pend <= 1'b0;
            cmd_end    <= 1'b0;
        end else begin
            if (code_we && !walk_busy && !start_pend) cmd_code <= code_wdata;
            start_pend <= accept;
            if (walk_done)    cmd_end <= 1'b1;
            else if (end_clr) cmd_end <= 1'b0;
        end
    end
endmodule

// File: rtl/rm_walker.sv
module rm_walker
    import rm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [2:0]       cmd,
    input  logic [RNG_W-1:0] range_lo,
    input  logic [RNG_W-1:0] range_hi,
    input  logic             grant,
    input  tag_ent_t         rdata,
    input  logic             wb_ack,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx,
    output logic             we,
    output tag_ent_t         wdata,
    output logic             wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic             wb_priv
);
    typedef enum logic [1:0] {W_IDLE, W_SCAN, W_WAIT, W_UPD} wstate_e;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    wstate_e          state;
    tag_ent_t         cap;
    logic [SET_W-1:0] cur_set;
    logic             hit, need_wb, adv;

    assign cur_set = idx[IDX_W-1:WAY_W];
    assign hit     = line_in_window(rdata, cur_set, range_lo, range_hi);
    assign need_wb = hit && rdata.dirty && cmd_cleans(cmd);

    always_comb begin
        we    = 1'b0;
        wdata = rdata;
        adv   = 1'b0;
        case (state)
            W_SCAN: if (grant && !need_wb) begin
                adv = 1'b1;
                if (hit && cmd_invals(cmd)) begin
                    we    = 1'b1;
                    wdata = '0;
                end
            end
            W_UPD: if (grant) begin
                adv = 1'b1;
                we  = 1'b1;
                if (cmd_invals(cmd)) begin
                    wdata = '0;
                end else begin
                    wdata       = cap;
                    wdata.dirty = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_IDLE;
            idx   <= '0;
            cap   <= '0;
        end else begin
            case (state)
                W_IDLE: if (launch) begin
                    state <= W_SCAN;
                    idx   <= '0;
                end
                W_SCAN: if (grant && need_wb) begin
                    cap   <= rdata;
                    state <= W_WAIT;
                end
                W_WAIT: if (wb_ack) state <= W_UPD;
                default: ;
            endcase
            if (adv) begin
                if (idx == LAST_IDX) begin
                    state <= W_IDLE;
                end else begin
                    idx   <= idx + 1'b1;
                    state <= W_SCAN;
                end
            end
        end
    end

    assign busy    = (state != W_IDLE);
    assign done    = adv && (idx == LAST_IDX);
    assign wb_req  = (state == W_WAIT);
    assign wb_addr = {cap.tag, cur_set, {OFS_W{1'b0}}};
    assign wb_priv = cap.priv;
endmodule

// File: rtl/rm_range_maint.sv
module rm_range_maint
    import rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_en,
    input  logic              full_inv_busy,
    input  logic              code_we,
    input  logic [2:0]        code_wdata,
    input  logic              start_req,
    input  logic              end_clr,
    input  logic [RNG_W-1:0]  range_lo,
    input  logic [RNG_W-1:0]  range_hi,
    input  logic              lk_req,
    input  logic              lk_we,
    input  logic [WAY_W-1:0]  lk_way,
    input  logic [SET_W-1:0]  lk_set,
    input  logic              lk_wvalid,
    input  logic              lk_wdirty,
    input  logic              lk_wpriv,
    input  logic [TAG_W-1:0]  lk_wtag,
    output logic              lk_rvalid,
    output logic              lk_rdirty,
    output logic              lk_rpriv,
    output logic [TAG_W-1:0]  lk_rtag,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              wb_priv,
    output logic              wb_incr,
    input  logic              wb_ack,
    output logic [2:0]        cmd_code,
    output logic              start_pend,
    output logic              cmd_busy,
    output logic              cmd_end
);
    logic             walk_done, walk_we;
    logic [IDX_W-1:0] walk_idx;
    tag_ent_t         walk_wdata, st_rdata, st_wdata;
    logic [IDX_W-1:0] st_addr;
    logic             st_we;

    rm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cache_en(cache_en), .full_inv_busy(full_inv_busy),
        .code_we(code_we), .code_wdata(code_wdata), .start_req(start_req),
        .end_clr(end_clr), .walk_busy(cmd_busy), .walk_done(walk_done),
        .cmd_code(cmd_code), .start_pend(start_pend), .cmd_end(cmd_end)
    );

    rm_walker u_walk (
        .clk(clk), .rst(rst), .launch(start_pend), .cmd(cmd_code),
        .range_lo(range_lo), .range_hi(range_hi), .grant(!lk_req),
        .rdata(st_rdata), .wb_ack(wb_ack), .busy(cmd_busy), .done(walk_done),
        .idx(walk_idx), .we(walk_we), .wdata(walk_wdata),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_priv(wb_priv)
    );

    always_comb begin
        if (lk_req) begin
            st_addr  = {lk_set, lk_way};
            st_we    = lk_we;
            st_wdata = '{valid: lk_wvalid, dirty: lk_wdirty, priv: lk_wpriv, tag: lk_wtag};
        end else begin
            st_addr  = walk_idx;
            st_we    = walk_we;
            st_wdata = walk_wdata;
        end
    end

    rm_tag_store u_store (
        .clk(clk), .rst(rst), .addr(st_addr), .we(st_we),
        .wdata(st_wdata), .rdata(st_rdata)
    );

    assign lk_rvalid = st_rdata.valid;
    assign lk_rdirty = st_rdata.dirty;
    assign lk_rpriv  = st_rdata.priv;
    assign lk_rtag   = st_rdata.tag;
    assign wb_incr   = wb_req;
endmodule

// File: rtl/rm_checker.sv
module rm_checker
    import rm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_req,
    input logic              start_pend,
    input logic              cmd_busy,
    input logic              cmd_end,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_priv,
    input logic [2:0]        cmd_code,
    input logic [IDX_W-1:0]  walk_idx
);
    a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_busy) |-> $past(start_pend));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_pend |=> (!start_pend && cmd_busy));

    a_r3_code_frozen: assert property (@(posedge clk) disable iff (rst)
        cmd_busy |=> $stable(cmd_code));

    a_r8_walk_yields: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && lk_req) |=> $stable(walk_idx));

    a_r9_wb_held: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_priv)));

    a_r11_end_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_busy) |-> cmd_end);

    a_r9_wb_only_busy: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> cmd_busy);
endmodule

bind rm_range_maint rm_checker u_chk (
    .clk(clk), .rst(rst), .lk_req(lk_req), .start_pend(start_pend),
    .cmd_busy(cmd_busy), .cmd_end(cmd_end), .wb_req(wb_req), .wb_ack(wb_ack),
    .wb_addr(wb_addr), .wb_priv(wb_priv), .cmd_code(cmd_code), .walk_idx(walk_idx)
);

// File: tb/tb_rm_range_maint.sv
module tb_rm_range_maint;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b1, full_inv_busy = 1'b0;
    logic        code_we = 1'b0, start_req = 1'b0, end_clr = 1'b0;
    logic [2:0]  code_wdata = 3'b0;
    logic [27:0] range_lo = '0, range_hi = '0;
    logic        lk_req = 1'b0, lk_we = 1'b0, lk_way = 1'b0;
    logic [6:0]  lk_set = '0;
    logic        lk_wvalid = 1'b0, lk_wdirty = 1'b0, lk_wpriv = 1'b0;
    logic [20:0] lk_wtag = '0;
    logic        lk_rvalid, lk_rdirty, lk_rpriv;
    logic [20:0] lk_rtag;
    logic        wb_req, wb_priv, wb_incr;
    logic        wb_ack = 1'b0;
    logic [31:0] wb_addr;
    logic [2:0]  cmd_code;
    logic        start_pend, cmd_busy, cmd_end;

    rm_range_maint dut (.*);

    always #4 clk = ~clk;

    int vecs = 0, fails = 0;
    logic        mv [2][128];
    logic        md [2][128];
    logic        mp [2][128];
    logic [20:0] mt [2][128];
    logic [31:0] exp_addr [512];
    logic        exp_priv [512];
    int          exp_n, got_n;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic put(input int w, input int s, input logic v, input logic d,
                       input logic p, input logic [20:0] t);
        @(negedge clk);
        lk_req = 1; lk_we = 1; lk_way = w[0]; lk_set = s[6:0];
        lk_wvalid = v; lk_wdirty = d; lk_wpriv = p; lk_wtag = t;
        mv[w][s] = v; md[w][s] = d; mp[w][s] = p; mt[w][s] = t;
    endtask

    task automatic release_port();
        @(negedge clk);
        lk_req = 0; lk_we = 0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 2; w++) put(w, s, 0, 0, 0, '0);
        release_port();
    endtask

    function automatic logic in_win(input int w, input int s, input logic [27:0] lo,
                                    input logic [27:0] hi);
        logic [27:0] la;
        la = {mt[w][s], s[6:0]};
        return mv[w][s] && la >= lo && la <= hi;
    endfunction

    task automatic model(input logic [2:0] c, input logic [27:0] lo, input logic [27:0] hi);
        bit cl, iv;
        cl = (c == 3'b001) || (c == 3'b011);
        iv = (c == 3'b010) || (c == 3'b011);
        exp_n = 0;
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 2; w++)
                if (in_win(w, s, lo, hi)) begin
                    if (cl && md[w][s]) begin
                        exp_addr[exp_n] = {mt[w][s], s[6:0], 4'b0000};
                        exp_priv[exp_n] = mp[w][s];
                        exp_n++;
                        md[w][s] = 0;
                    end
                    if (iv) begin
                        mv[w][s] = 0; md[w][s] = 0; mp[w][s] = 0; mt[w][s] = '0;
                    end
                end
    endtask

    task automatic launch(input logic [2:0] c, input logic [27:0] lo, input logic [27:0] hi);
        @(negedge clk);
        code_we = 1; code_wdata = c; range_lo = lo; range_hi = hi;
        @(negedge clk);
        code_we = 0; start_req = 1;
        @(negedge clk);
        start_req = 0;
        chk(start_pend == 1 && cmd_busy == 0, "R2 pend", {start_pend, cmd_busy}, 2'b10);
        @(negedge clk);
        chk(start_pend == 0 && cmd_busy == 1, "R2 busy", {start_pend, cmd_busy}, 2'b01);
    endtask

    task automatic run_walk(input bit rnd_lk);
        bit seen = 0;
        int dly = 0;
        got_n = 0;
        while (cmd_busy) begin
            wb_ack = 0;
            if (wb_req) begin
                if (!seen) begin
                    chk(wb_incr == 1, "R10 incr", wb_incr, 1);
                    if (got_n < exp_n) begin
                        chk(wb_addr == exp_addr[got_n], "R9 R10 addr", wb_addr, exp_addr[got_n]);
                        chk(wb_priv == exp_priv[got_n], "R10 priv", wb_priv, exp_priv[got_n]);
                    end else chk(0, "R6 extra write-back", wb_addr, 0);
                    got_n++;
                    seen = 1;
                    dly = $urandom % 4;
                end
                if (dly == 0) begin
                    wb_ack = 1; seen = 0;
                end else dly--;
            end
            lk_req = rnd_lk && ($urandom % 3 == 0);
            lk_we = 0; lk_way = $urandom % 2; lk_set = $urandom % 128;
            @(negedge clk);
        end
        wb_ack = 0; lk_req = 0;
        chk(got_n == exp_n, "R6 R7 write-back count", got_n, exp_n);
        chk(cmd_end == 1, "R11 end set", cmd_end, 1);
    endtask

    task automatic verify_all(input string req);
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 2; w++) begin
                @(negedge clk);
                lk_req = 1; lk_we = 0; lk_way = w[0]; lk_set = s[6:0];
                #1;
                chk({lk_rvalid, lk_rdirty, lk_rpriv, lk_rtag} ==
                    {mv[w][s], md[w][s], mp[w][s], mt[w][s]}, req,
                    {lk_rvalid, lk_rdirty, lk_rpriv, lk_rtag},
                    {mv[w][s], md[w][s], mp[w][s], mt[w][s]});
            end
        release_port();
    endtask

    task automatic clr_end();
        @(negedge clk); end_clr = 1;
        @(negedge clk); end_clr = 0;
        chk(cmd_end == 0, "R11 end cleared", cmd_end, 0);
    endtask

    task automatic try_reject(input string req);
        @(negedge clk); start_req = 1;
        @(negedge clk); start_req = 0;
        chk(start_pend == 0, req, start_pend, 0);
        @(negedge clk);
        chk(cmd_busy == 0, req, cmd_busy, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 2; w++) begin
                mv[w][s] = 0; md[w][s] = 0; mp[w][s] = 0; mt[w][s] = '0;
            end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk({cmd_code, start_pend, cmd_busy, cmd_end, wb_req} == 0, "R12 flags",
            {cmd_code, start_pend, cmd_busy, cmd_end, wb_req}, 0);
        verify_all("R12 store empty");

        // R1 rejections
        @(negedge clk); code_we = 1; code_wdata = 3'b100;
        @(negedge clk); code_we = 0;
        try_reject("R1 reserved code");
        @(negedge clk); code_we = 1; code_wdata = 3'b000;
        @(negedge clk); code_we = 0;
        try_reject("R1 nop code");
        @(negedge clk); code_we = 1; code_wdata = 3'b001;
        @(negedge clk); code_we = 0; cache_en = 0;
        try_reject("R1 cache disabled");
        cache_en = 1; full_inv_busy = 1;
        try_reject("R1 full invalidate busy");
        full_inv_busy = 0;

        // R4 R6 boundaries with clean
        put(0, 10, 1, 1, 1, 21'h00ABC);
        put(1, 9,  1, 1, 0, 21'h00ABC);
        put(1, 20, 1, 1, 0, 21'h00ABC);
        put(0, 21, 1, 1, 1, 21'h00ABC);
        put(0, 15, 1, 0, 1, 21'h00ABC);
        release_port();
        model(3'b001, {21'h00ABC, 7'd10}, {21'h00ABC, 7'd20});
        chk(exp_n == 2, "R4 model window", exp_n, 2);
        launch(3'b001, {21'h00ABC, 7'd10}, {21'h00ABC, 7'd20});
        run_walk(0);
        verify_all("R4 R6 clean boundaries");
        clr_end();

        // R5 invalidate on same window
        model(3'b010, {21'h00ABC, 7'd10}, {21'h00ABC, 7'd20});
        launch(3'b010, {21'h00ABC, 7'd10}, {21'h00ABC, 7'd20});
        run_walk(1);
        verify_all("R5 invalidate");
        clr_end();

        // R8 preemption, plus R1 start-while-busy and R3 code write while busy
        put(1, 40, 1, 1, 1, 21'h00123);
        put(0, 41, 1, 1, 0, 21'h00123);
        release_port();
        model(3'b011, {21'h00123, 7'd0}, {21'h00123, 7'd127});
        launch(3'b011, {21'h00123, 7'd0}, {21'h00123, 7'd127});
        begin
            int wbs = 0;
            @(negedge clk); lk_req = 1; lk_we = 0; lk_set = 0; lk_way = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (wb_req) wbs++;
            end
            chk(cmd_busy == 1 && wbs == 0, "R8 walk frozen", {cmd_busy, wbs[7:0]}, 9'h100);
        end
        lk_req = 0;
        start_req = 1; code_we = 1; code_wdata = 3'b001;
        @(negedge clk); start_req = 0; code_we = 0;
        chk(start_pend == 0, "R1 start while busy", start_pend, 0);
        chk(cmd_code == 3'b011, "R3 code write while busy", cmd_code, 3'b011);
        run_walk(1);
        verify_all("R7 clean and invalidate");
        clr_end();

        // random rounds R4 R6 R7 R9 R10
        for (int r = 0; r < 5; r++) begin
            logic [20:0] base;
            logic [27:0] lo, hi;
            logic [2:0]  c;
            base = 21'h01000 + r[20:0] * 8;
            for (int s = 0; s < 128; s++)
                for (int w = 0; w < 2; w++)
                    put(w, s, $urandom % 4 != 0, $urandom % 2, $urandom % 2,
                        base + 21'($urandom % 3));
            release_port();
            lo = {base + 21'($urandom % 2), 7'($urandom % 128)};
            hi = lo + 28'($urandom % 300);
            c  = 3'(1 + ($urandom % 3));
            model(c, lo, hi);
            launch(c, lo, hi);
            run_walk(1);
            verify_all(c == 3'b001 ? "R6 random" : (c == 3'b010 ? "R5 random" : "R7 random"));
            clr_end();
        end
        clear_all();

        summary();
        $finish;
    end
endmodule